// File: doc/BRIEF.md
# Masked Vector Element Execution Unit

This block runs one element-wise vector operation at a time over two operand vectors, gated by a per-element mask that it holds internally. Operand storage sits outside: the unit drives an element read index, and the surrounding register file answers in the same cycle with the A and B elements at that index. Each issued element produces a registered result that carries its element index and a write enable, so the write-back port can store it in the right slot.

Arithmetic operations (add, multiply, masked move) run in one of two styles, chosen when the operation starts. In the sequential style every element in the active length is stepped through, one per cycle, and the write enable follows the mask bit. In the skip style a priority encoder jumps straight to the next set mask bit each cycle, so only active elements spend a cycle. Test operations write the mask, one bit per element, and an invert operation flips the mask over the active length in a single cycle. This covers conditional loops such as "take A where A >= B, otherwise B".

Top module: `mvec_masked_exec`

## Requirements
- R1: After reset the unit is idle (busy low, res_we low) and every mask bit is 1.
- R2: Arithmetic codes are op=0 add (sum modulo 2^EW), op=1 multiply (low EW bits of the product), and op=2 move (result is the A element).
- R3: Test codes are op=3 (mask bit set when A is nonzero) and op=4 (mask bit set when A >= B, both taken as signed two's complement). They step through elements 0 to L-1 one per cycle whatever the mode bit says, never assert res_we, and leave mask bits at index L and above unchanged.
- R4: op=5 inverts mask bits 0 to L-1 at the start edge. It does not raise busy, and bits at index L and above keep their values.
- R5: With dens_mode=0, an arithmetic operation keeps busy high for exactly L cycles. It issues elements 0 to L-1 in order, and res_we for each equals that element's mask bit.
- R6: With dens_mode=1, an arithmetic operation issues only the elements below L whose mask bit is 1, in ascending index order, one per cycle, each with res_we=1. Busy stays high for exactly that many cycles. If no such element exists, busy never rises.
- R7: An element whose index is on rd_idx during a busy cycle appears on res_idx and res_data on the next cycle.
- R8: The active length L is vlen clamped to NELEM. vlen=0 and the unused codes op=6 and op=7 start nothing and leave the mask unchanged.
- R9: start is ignored while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op | input | 3 | Operation code |
| dens_mode | input | 1 | 1 selects the skip style for arithmetic operations |
| vlen | input | $clog2(NELEM+1) | Requested vector length |
| busy | output | 1 | Operation in progress |
| rd_idx | output | $clog2(NELEM) | Element index being read from operand storage |
| a_elem | input | EW | A element at rd_idx |
| b_elem | input | EW | B element at rd_idx |
| res_we | output | 1 | Result write enable |
| res_idx | output | $clog2(NELEM) | Element index of the result |
| res_data | output | EW | Result element |

## Verification
The bench builds the unit with NELEM=8 and EW=8. The 4-bit vlen port can then request lengths up to 15, which puts the clamp to 8 within reach. The 8-bit elements make add and multiply overflow and signed-compare sign boundaries (0x80 against small positives) common under random stimulus. With eight elements, random masks regularly produce empty, full and sparse skip-style scans, including the case where the last active element is index 7.

// File: rtl/mvec_pkg.sv
package mvec_pkg;

    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_MUL   = 3'd1,
        OP_MOVA  = 3'd2,
        OP_TSTNZ = 3'd3,
        OP_TSTGE = 3'd4,
        OP_MINV  = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } vop_e;

    typedef enum logic {
        STYLE_SEQ  = 1'b0,
        STYLE_SKIP = 1'b1
    } vstyle_e;

    function automatic logic is_arith(vop_e op);
        return (op == OP_ADD) || (op == OP_MUL) || (op == OP_MOVA);
    endfunction

    function automatic logic is_test(vop_e op);
        return (op == OP_TSTNZ) || (op == OP_TSTGE);
    endfunction

endpackage

// File: rtl/mvec_alu.sv
module mvec_alu
    import mvec_pkg::*;
#(
    parameter int EW = 16
) (
    input  vop_e          op,
    input  logic [EW-1:0] a,
    input  logic [EW-1:0] b,
    output logic [EW-1:0] res,
    output logic          tbit
);
    logic [2*EW-1:0] prod;

    always_comb begin
        prod = a * b;
        res  = '0;
        tbit = 1'b0;
        case (op)
            OP_ADD:   res = a + b;
            OP_MUL:   res = prod[EW-1:0];
            OP_MOVA:  res = a;
            OP_TSTNZ: tbit = (a != '0);
            OP_TSTGE: tbit = ($signed(a) >= $signed(b));
            default:  res = '0;
        endcase
    end
endmodule

// File: rtl/mvec_scan.sv
module mvec_scan #(
    parameter int NELEM = 16,
    localparam int IW = (NELEM > 1) ? $clog2(NELEM) : 1,
    localparam int LW = $clog2(NELEM + 1)
) (
    input  logic [NELEM-1:0] vec,
    input  logic [LW-1:0]    lo,
    output logic             found,
    output logic [IW-1:0]    idx
);
    logic [NELEM-1:0] qual;

    for (genvar g = 0; g < NELEM; g++) begin : g_qual
        assign qual[g] = vec[g] && (LW'(g) >= lo);
    end

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NELEM - 1; i >= 0; i--) begin
            if (qual[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/mvec_mask.sv
module mvec_mask #(
    parameter int NELEM = 16,
    localparam int IW = (NELEM > 1) ? $clog2(NELEM) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic             wr_bit,
    input  logic             inv_en,
    input  logic [NELEM-1:0] inv_sel,
    output logic [NELEM-1:0] mask
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '1;
        end else if (inv_en) begin
            mask <= mask ^ inv_sel;
        end else if (wr_en) begin
            mask[wr_idx] <= wr_bit;
        end
    end

    // R4: bits outside the inverted range hold their value
    a_r4_inv_keeps_tail: assert property (@(posedge clk) disable iff (rst)
        inv_en |=> ((mask & ~$past(inv_sel)) == ($past(mask) & ~$past(inv_sel))));

    // R3: a single-element write touches no other bit
    a_r3_one_bit_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !inv_en) |=> ($countones(mask ^ $past(mask)) <= 1));
endmodule

// File: rtl/mvec_masked_exec.sv
module mvec_masked_exec
    import mvec_pkg::*;
#(
    parameter int NELEM = 16,
    parameter int EW    = 16,
    localparam int IW = (NELEM > 1) ? $clog2(NELEM) : 1,
    localparam int LW = $clog2(NELEM + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [2:0]    op,
    input  logic          dens_mode,
    input  logic [LW-1:0] vlen,
    output logic          busy,
    output logic [IW-1:0] rd_idx,
    input  logic [EW-1:0] a_elem,
    input  logic [EW-1:0] b_elem,
    output logic          res_we,
    output logic [IW-1:0] res_idx,
    output logic [EW-1:0] res_data
);
    vop_e             op_in, op_q;
    vstyle_e          style_q;
    logic [LW-1:0]    len_in, len_q, eff_len, scan_lo;
    logic [IW-1:0]    cur;
    logic [NELEM-1:0] mask, len_sel, act_vec;
    logic             accept, scan_found, tbit;
    logic [IW-1:0]    scan_idx;
    logic [EW-1:0]    alu_res;

    assign op_in   = vop_e'(op);
    assign len_in  = (vlen > LW'(NELEM)) ? LW'(NELEM) : vlen;
    assign accept  = start && !busy;
    assign eff_len = busy ? len_q : len_in;

    for (genvar g = 0; g < NELEM; g++) begin : g_len
        assign len_sel[g] = (LW'(g) < eff_len);
    end

    assign act_vec = mask & len_sel;
    assign scan_lo = busy ? (LW'(cur) + LW'(1)) : '0;
    assign rd_idx  = cur;

    mvec_scan #(.NELEM(NELEM)) scan_i (
        .vec   (act_vec),
        .lo    (scan_lo),
        .found (scan_found),
        .idx   (scan_idx)
    );

    mvec_alu #(.EW(EW)) alu_i (
        .op   (op_q),
        .a    (a_elem),
        .b    (b_elem),
        .res  (alu_res),
        .tbit (tbit)
    );

    mvec_mask #(.NELEM(NELEM)) mask_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (busy && is_test(op_q)),
        .wr_idx  (cur),
        .wr_bit  (tbit),
        .inv_en  (accept && (op_in == OP_MINV)),
        .inv_sel (len_sel),
        .mask    (mask)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            cur      <= '0;
            op_q     <= OP_ADD;
            style_q  <= STYLE_SEQ;
            len_q    <= '0;
            res_we   <= 1'b0;
            res_idx  <= '0;
            res_data <= '0;
        end else if (busy) begin
            res_we   <= is_arith(op_q) && ((style_q == STYLE_SKIP) || mask[cur]);
            res_idx  <= cur;
            res_data <= alu_res;
            if (style_q == STYLE_SKIP) begin
                if (scan_found) cur <= scan_idx;
                else            busy <= 1'b0;
            end else if (LW'(cur) == len_q - LW'(1)) begin
                busy <= 1'b0;
            end else begin
                cur <= cur + IW'(1);
            end
        end else begin
            res_we <= 1'b0;
            if (accept && (len_in != '0)) begin
                op_q  <= op_in;
                len_q <= len_in;
                if (is_arith(op_in) && dens_mode) begin
                    style_q <= STYLE_SKIP;
                    if (scan_found) begin
                        busy <= 1'b1;
                        cur  <= scan_idx;
                    end
                end else if (is_arith(op_in) || is_test(op_in)) begin
                    style_q <= STYLE_SEQ;
                    busy    <= 1'b1;
                    cur     <= '0;
                end
            end
        end
    end

    // R9: busy rises only from an accepted start
    a_r9_rise_from_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    // R5: the sequential style steps one element per cycle
    a_r5_seq_step: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && style_q == STYLE_SEQ) |-> (rd_idx == $past(rd_idx) + IW'(1)));

    // R6: the skip style only moves upward
    a_r6_skip_ascends: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && style_q == STYLE_SKIP) |-> (rd_idx > $past(rd_idx)));

    // R6: every skip-style write targets an active element
    a_r6_skip_active: assert property (@(posedge clk) disable iff (rst)
        (res_we && style_q == STYLE_SKIP) |-> mask[res_idx]);

    // R7: written results stay inside the active length
    a_r7_idx_in_len: assert property (@(posedge clk) disable iff (rst)
        res_we |-> (LW'(res_idx) < len_q));

    // R3: test operations never write a result
    a_r3_test_silent: assert property (@(posedge clk) disable iff (rst)
        ($past(busy) && is_test(op_q)) |-> !res_we);

    // R1: no write without a busy cycle before it
    a_r1_we_needs_busy: assert property (@(posedge clk) disable iff (rst)
        res_we |-> $past(busy));
endmodule

// File: tb/mvec_masked_exec_tb.sv
module mvec_masked_exec_tb_top;
    localparam int NE = 8;
    localparam int EW = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [2:0] op = 3'd0;
    logic       dens_mode = 1'b0;
    logic [3:0] vlen = 4'd0;
    logic       busy, res_we;
    logic [2:0] rd_idx, res_idx;
    logic [EW-1:0] a_elem, b_elem, res_data;

    logic [EW-1:0] A [NE];
    logic [EW-1:0] B [NE];
    logic [NE-1:0] mdl_mask;
    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    assign a_elem = A[rd_idx];
    assign b_elem = B[rd_idx];

    mvec_masked_exec #(.NELEM(NE), .EW(EW)) dut_i (
        .clk(clk), .rst(rst), .start(start), .op(op), .dens_mode(dens_mode),
        .vlen(vlen), .busy(busy), .rd_idx(rd_idx), .a_elem(a_elem), .b_elem(b_elem),
        .res_we(res_we), .res_idx(res_idx), .res_data(res_data)
    );

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [EW-1:0] exp_data(input int o, input logic [EW-1:0] a, input logic [EW-1:0] b);
        logic [2*EW-1:0] p;
        p = a * b;
        case (o)
            0: return a + b;
            1: return p[EW-1:0];
            default: return a;
        endcase
    endfunction

    task automatic run(input int o, input bit md, input int vl, input bit poke);
        int L, cnt;
        int eidx [NE];
        bit ewe [NE];
        string tag;
        L = (vl > NE) ? NE : vl;
        cnt = 0;
        if (o <= 2) begin
            tag = md ? "R6" : "R5";
            for (int i = 0; i < L; i++) begin
                if (!md || mdl_mask[i]) begin
                    eidx[cnt] = i; ewe[cnt] = md ? 1'b1 : mdl_mask[i]; cnt++;
                end
            end
        end else if (o <= 4) begin
            tag = "R3";
            for (int i = 0; i < L; i++) begin
                eidx[cnt] = i; ewe[cnt] = 1'b0; cnt++;
            end
        end else if (o == 5) begin
            tag = "R4";
        end else begin
            tag = "R8";
        end
        if (vl == 0) tag = "R8";
        @(negedge clk);
        start = 1'b1; op = 3'(o); dens_mode = md; vlen = 4'(vl);
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            start = 1'b1; op = 3'd5; vlen = 4'd8;  // R9: must be ignored
        end
        chk(tag, "busy after start", busy, cnt > 0);
        if (cnt == 0) chk(tag, "no write when idle", res_we, 0);
        for (int k = 0; k < cnt; k++) begin
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            chk(tag, "write enable", res_we, ewe[k]);
            chk("R7", "result index", res_idx, eidx[k]);
            if (ewe[k]) chk("R2", "result data", res_data, exp_data(o, A[eidx[k]], B[eidx[k]]));
            chk(tag, "busy length", busy, k < cnt - 1);
        end
        if (o == 3) for (int i = 0; i < L; i++) mdl_mask[i] = (A[i] != 0);
        if (o == 4) for (int i = 0; i < L; i++) mdl_mask[i] = ($signed(A[i]) >= $signed(B[i]));
        if (o == 5) for (int i = 0; i < L; i++) mdl_mask[i] = ~mdl_mask[i];
        @(negedge clk);
    endtask

    task automatic rand_ops();
        for (int i = 0; i < NE; i++) begin
            A[i] = ($urandom % 4 == 0) ? '0 : EW'($urandom);
            B[i] = EW'($urandom);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        mdl_mask = '1;
        for (int i = 0; i < NE; i++) begin A[i] = EW'(i + 1); B[i] = EW'(3 * i); end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1", "busy at reset", busy, 0);
        chk("R1", "res_we at reset", res_we, 0);
        run(2, 1'b0, 8, 1'b0);               // R1: all mask bits set -> all writes
        // R3 signed compare corners
        A[0] = 8'h80; B[0] = 8'h01;
        A[1] = 8'h01; B[1] = 8'h80;
        A[2] = 8'h05; B[2] = 8'h05;
        A[3] = 8'hFF; B[3] = 8'h00;
        A[4] = 8'h7F; B[4] = 8'h80;
        run(4, 1'b1, 5, 1'b0);
        run(2, 1'b0, 8, 1'b0);               // reveals mask bits (tail kept)
        // R2 overflow
        A[5] = 8'hFF; B[5] = 8'h02;
        A[6] = 8'h10; B[6] = 8'h11;
        run(0, 1'b0, 8, 1'b0);
        run(1, 1'b0, 8, 1'b0);
        run(5, 1'b0, 5, 1'b0);               // R4 partial invert
        run(2, 1'b1, 8, 1'b0);               // R6 skip
        run(0, 1'b1, 12, 1'b0);              // R8 clamp
        run(0, 1'b0, 0, 1'b0);               // R8 zero length
        run(6, 1'b0, 8, 1'b0);               // R8 unused code
        run(7, 1'b1, 8, 1'b0);
        run(2, 1'b0, 8, 1'b1);               // R9 start while busy
        run(2, 1'b1, 8, 1'b0);
        // R6 empty scan
        for (int i = 0; i < NE; i++) A[i] = '0;
        run(3, 1'b0, 8, 1'b0);
        run(1, 1'b1, 8, 1'b0);
        // R6 only last element active
        A[7] = 8'h09;
        run(3, 1'b1, 8, 1'b0);
        run(0, 1'b1, 8, 1'b0);
        for (int n = 0; n < 300; n++) begin
            rand_ops();
            run(int'($urandom % 8), 1'($urandom), int'($urandom % 16), 1'b0);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule